// File: doc/BRIEF.md
# External Bus Ownership Requester

This block sits between a processor core and a shared external bus that several masters use in turn. The core raises a one-clock access strobe when it needs an external access. The block then raises a bus request towards an outside arbiter. Once the arbiter's grant is seen and the shared busy line is free, the block takes ownership and drives busy itself. It then runs the bus cycle for a fixed number of clocks and reports completion to the core.

Ownership may be kept after the work is done, which is bus parking. While parked, the request is low but busy stays driven and the grant stays high, so a later access starts without a new arbitration. When the arbiter withdraws grant, the block lets any running cycle finish. It then hands the bus back by driving busy high for one clock and tri-stating it, so an external pull-up holds the line.

A software hold bit keeps the request asserted with no access pending. A low-power flag governs what the request does while the core is stopped. An enable input routes grant and busy through two-stage synchronizers when the arbiter runs on an unrelated clock.

Top module: `bus_arb_requester`

## Requirements
- R1: While reset is held, `br_o`, `is_master`, `cyc_done` and `bb_n_oe` are all 0, whatever `bg_i`, `bb_n_i` and `acc_req` carry. After reset the block is a bus slave.
- R2: An `acc_req` pulse makes an access pending on the next edge, and `br_o` rises one edge later. A pulse that arrives while an access is already pending is ignored. `br_o` falls one edge after the pending access completes, unless `req_hold` is 1.
- R3: Outside low power, `br_o` follows pending OR `req_hold` one edge later. With `lowpower` = 1, `br_o` keeps its last value if `req_hold` = 1, and becomes 0 if `req_hold` = 0.
- R4: After grant is seen, the block becomes master only on the edge after it samples busy released (`bb_n_i` = 1). From slave with the bus free, `is_master` rises on the second edge that samples grant.
- R5: While master, busy is driven low: `bb_n_oe` = 1 and `bb_n_o` = 0.
- R6: Once the pending access ends with grant still held, `is_master` stays 1 and busy stays driven while `br_o` falls. This is bus parking.
- R7: If grant is withdrawn during a bus cycle, the cycle completes with `cyc_done`. The block leaves mastership on the edge that ends that cycle.
- R8: On leaving mastership, the block drives `bb_n_o` = 1 with `bb_n_oe` = 1 for exactly one clock, then releases the line (`bb_n_oe` = 0).
- R9: A bus cycle starts only as master, with an access pending and grant seen. It lasts `CYC_LEN` clocks, and `cyc_done` is high in its last clock. A parked master starts the cycle on the edge after the pending access registers.
- R10: With `async_en` = 1, grant and busy are seen two clocks later than with `async_en` = 0.
- R11: `bb_n_oe` is 1 only while master or during the single release clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | One-clock strobe: the core needs an external access |
| req_hold | input | 1 | Software bit forcing the request high |
| lowpower | input | 1 | Core is in stop/wait |
| async_en | input | 1 | Route grant and busy through the synchronizers |
| bg_i | input | 1 | Bus grant from the arbiter, active high |
| bb_n_i | input | 1 | Shared busy line as sampled, active low |
| br_o | output | 1 | Bus request to the arbiter, active high |
| bb_n_o | output | 1 | Value driven onto the busy line |
| bb_n_oe | output | 1 | Output enable for the busy line |
| is_master | output | 1 | Block currently owns the bus |
| cyc_done | output | 1 | High in the last clock of a bus cycle |

## Verification
The assertions assume the arbiter changes grant only between clock edges. They also assume the busy line reads high whenever nobody drives it, which means an external pull-up is present.

The bench models the shared line as a resolved net. Its value is the block's own drive when enabled, otherwise a low from a modelled rival master, otherwise the pull-up's high. Grant is only ever applied as a clean level, and `async_en` is changed only while the block is an idle slave, after the synchronizers have settled.

// File: rtl/bus_arb_requester.sv
module bus_arb_requester #(
  parameter int CYC_LEN    = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic req_hold,
  input  logic lowpower,
  input  logic async_en,
  input  logic bg_i,
  input  logic bb_n_i,
  output logic br_o,
  output logic bb_n_o,
  output logic bb_n_oe,
  output logic is_master,
  output logic cyc_done
);
  localparam int CW = $clog2(CYC_LEN);
  localparam logic [CW-1:0] LAST = CW'(CYC_LEN - 1);

  typedef enum logic [1:0] {ST_SLAVE, ST_WAIT, ST_MASTER} st_t;

  st_t state;
  logic [SYNC_DEPTH-1:0] g_sync, b_sync;
  logic [CW-1:0] cnt;
  logic pend, active, rel, br_q;
  logic g_seen, free_seen, last, start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      g_sync <= '0;
      b_sync <= '1;
    end else begin
      g_sync <= {g_sync[SYNC_DEPTH-2:0], bg_i};
      b_sync <= {b_sync[SYNC_DEPTH-2:0], bb_n_i};
    end

  assign g_seen    = async_en ? g_sync[SYNC_DEPTH-1] : bg_i;
  assign free_seen = async_en ? b_sync[SYNC_DEPTH-1] : bb_n_i;
  assign last      = active && (cnt == LAST);
  assign start     = (state == ST_MASTER) && pend && !active && g_seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend   <= 1'b0;
      br_q   <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      if (!pend && acc_req) pend <= 1'b1;
      else if (last)        pend <= 1'b0;

      if (lowpower) br_q <= req_hold ? br_q : 1'b0;
      else          br_q <= pend | req_hold;

      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (last) begin
        active <= 1'b0;
      end else if (active) begin
        cnt <= cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_SLAVE;
      rel   <= 1'b0;
    end else begin
      rel <= 1'b0;
      case (state)
        ST_SLAVE:  if (g_seen) state <= ST_WAIT;
        ST_WAIT:   if (!g_seen) state <= ST_SLAVE;
                   else if (free_seen) state <= ST_MASTER;
        ST_MASTER: if (!g_seen && (!active || last)) begin
                     state <= ST_SLAVE;
                     rel   <= 1'b1;
                   end
        default:   state <= ST_SLAVE;
      endcase
    end

  assign is_master = (state == ST_MASTER);
  assign bb_n_oe   = is_master | rel;
  assign bb_n_o    = !is_master;
  assign br_o      = br_q;
  assign cyc_done  = last;

  assert_entry_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_master) |-> $past(free_seen) && $past(g_seen));
  assert_drive_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> bb_n_oe && !bb_n_o);
  assert_done_as_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> is_master);
  assert_release_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(is_master) |-> bb_n_oe && bb_n_o);
  assert_release_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bb_n_oe && !is_master) |=> !bb_n_oe);
  assert_start_granted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(g_seen) && $past(pend));
  assert_lp_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpower && !req_hold) |=> !br_o);
  assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hold && !lowpower) |=> br_o);
endmodule

// File: tb/test_bus_arb_requester.sv
module test_bus_arb_requester;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_req = 0, req_hold = 0, lowpower = 0, async_en = 0, bg_i = 0, ext_busy = 0;
  logic br_o, bb_n_o, bb_n_oe, is_master, cyc_done, bb_n_bus;
  int checks = 0, errors = 0;
  bit seen;

  always #10 clk = ~clk;

  assign bb_n_bus = bb_n_oe ? bb_n_o : (ext_busy ? 1'b0 : 1'b1);

  bus_arb_requester #(.CYC_LEN(4), .SYNC_DEPTH(2)) i_bus_arb_requester (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .req_hold(req_hold),
    .lowpower(lowpower), .async_en(async_en), .bg_i(bg_i), .bb_n_i(bb_n_bus),
    .br_o(br_o), .bb_n_o(bb_n_o), .bb_n_oe(bb_n_oe), .is_master(is_master),
    .cyc_done(cyc_done));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic pulse_req();
    acc_req = 1'b1;
    tick();
    acc_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bg_i = 1; ext_busy = 1; acc_req = 1;
    repeat (3) @(negedge clk);
    chk("R1", "br in reset", br_o, 1'b0);
    chk("R1", "master in reset", is_master, 1'b0);
    chk("R1", "oe in reset", bb_n_oe, 1'b0);
    chk("R1", "done in reset", cyc_done, 1'b0);
    bg_i = 0; ext_busy = 0; acc_req = 0;
    rst_n = 1'b1;
    tick();
    chk("R1", "slave after reset", is_master, 1'b0);

    // request, grant, cycle, parking, release
    pulse_req();
    chk("R2", "br one edge after pending", br_o, 1'b0);
    tick();
    chk("R2", "br raised", br_o, 1'b1);
    bg_i = 1;
    tick();
    chk("R4", "not master on first grant edge", is_master, 1'b0);
    tick();
    chk("R4", "master on second grant edge", is_master, 1'b1);
    chk("R5", "busy oe", bb_n_oe, 1'b1);
    chk("R5", "busy low", bb_n_o, 1'b0);
    tick(); tick(); tick();
    chk("R9", "done not early", cyc_done, 1'b0);
    tick();
    chk("R9", "done at cycle end", cyc_done, 1'b1);
    tick();
    chk("R9", "done one clock", cyc_done, 1'b0);
    chk("R2", "br held until pend clears", br_o, 1'b1);
    tick();
    chk("R2", "br dropped after completion", br_o, 1'b0);
    chk("R6", "parked master", is_master, 1'b1);
    chk("R6", "parked busy driven", bb_n_oe, 1'b1);
    bg_i = 0;
    tick();
    chk("R8", "left master", is_master, 1'b0);
    chk("R8", "release oe", bb_n_oe, 1'b1);
    chk("R8", "release high", bb_n_o, 1'b1);
    tick();
    chk("R11", "line released", bb_n_oe, 1'b0);

    // busy held by a rival; grant removed mid-cycle
    ext_busy = 1; bg_i = 1;
    pulse_req();
    for (int k = 0; k < 5; k++) begin
      if (k == 2) acc_req = 1'b1;
      tick();
      acc_req = 1'b0;
      chk("R4", "wait while busy", is_master, 1'b0);
      chk("R11", "no drive while waiting", bb_n_oe, 1'b0);
    end
    ext_busy = 0;
    tick();
    chk("R4", "master after busy free", is_master, 1'b1);
    tick();
    bg_i = 0;
    tick();
    chk("R7", "still master mid-cycle", is_master, 1'b1);
    tick(); tick();
    chk("R7", "cycle completes", cyc_done, 1'b1);
    chk("R7", "master in last clock", is_master, 1'b1);
    tick();
    chk("R7", "left after cycle", is_master, 1'b0);
    chk("R8", "release high after cycle", bb_n_o & bb_n_oe, 1'b1);
    tick();
    chk("R8", "release one clock", bb_n_oe, 1'b0);
    chk("R2", "repeat strobe ignored", br_o, 1'b0);

    // parked reuse, and no start without grant
    bg_i = 1;
    tick(); tick();
    tick();
    chk("R6", "parked with no request", is_master & ~br_o, 1'b1);
    pulse_req();
    chk("R9", "no done yet", cyc_done, 1'b0);
    tick(); tick(); tick();
    chk("R9", "parked done edge 4", cyc_done, 1'b0);
    tick();
    chk("R9", "parked cycle length", cyc_done, 1'b1);
    chk("R9", "no rearbitration", is_master, 1'b1);
    tick();
    acc_req = 1; bg_i = 0;
    tick();
    acc_req = 0;
    chk("R9", "left without starting", is_master, 1'b0);
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      tick();
      if (cyc_done) seen = 1;
    end
    chk("R9", "no cycle without grant", seen, 1'b0);
    bg_i = 1;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (cyc_done) seen = 1;
    end
    chk("R9", "cycle after regrant", seen, 1'b1);
    bg_i = 0;
    tick(); tick(); tick();

    // synchronized arbitration
    async_en = 1;
    tick(); tick(); tick();
    bg_i = 1;
    tick(); tick(); tick();
    chk("R10", "no master at edge 3", is_master, 1'b0);
    tick();
    chk("R10", "master at edge 4", is_master, 1'b1);
    bg_i = 0;
    tick(); tick();
    chk("R10", "grant loss delayed", is_master, 1'b1);
    tick();
    chk("R10", "left after sync delay", is_master, 1'b0);
    tick(); tick(); tick();
    async_en = 0;
    tick();

    // request logic sweep over prior value, hold and low power
    for (int p = 0; p < 2; p++)
      for (int h = 0; h < 2; h++)
        for (int l = 0; l < 2; l++) begin
          lowpower = 0; req_hold = p[0];
          tick();
          chk("R3", "hold sets prior br", br_o, p[0]);
          req_hold = h[0]; lowpower = l[0];
          tick();
          chk("R3", "hold/lowpower result", br_o, l[0] ? (h[0] & p[0]) : h[0]);
        end
    lowpower = 0; req_hold = 0;
    tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule